// File: doc/BRIEF.md
# Ethernet PHY Management Register File with Interrupts

This block holds the management registers of a 10/100 Ethernet transceiver as a station manager sees them over a 5-bit clause-22 register address space. A host issues single-cycle read or write strobes with an address and 16-bit data. The block keeps the control, status, advertisement, interrupt-pending and interrupt-enable registers. It answers fixed values for the identifier words, the link-partner ability word and the expansion word. It also tracks a link-down input from the line side.

Autonegotiation is modelled as finishing at once. Link transitions update two status bits and post interrupt causes. Reading the pending register hands its contents back and empties it. A level interrupt output is raised whenever any pending cause is also enabled. Read data appears one cycle after the read strobe. The serial management framing and any real negotiation on the wire are handled elsewhere.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset with link up, address 0 reads 0x3000, address 1 reads 0x782D, address 4 reads 0x01E1, address 30 reads 0 and address 29 reads 0x00C0. The interrupt output is low.
- R2: `irq` is high exactly when the bitwise AND of the pending causes (address 29) and the enable mask (address 30) is nonzero.
- R3: A read of address 29 returns the pending causes and clears them in the same access. `irq` is low in the following cycle if no new cause arrived.
- R4: A write to address 30 stores only data bits 7:0, and reads return them with bits 15:8 zero. The new mask takes effect on `irq` in the next cycle.
- R5: A write to address 0 with bit 15 set is a soft reset. Every register returns to its R1 value, and the current link level is applied again to the status and pending bits.
- R6: A write to address 0 without bit 15 stores only bits 14 (loopback), 13 (speed 100), 12 (autoneg enable), 11 (power down), 8 (full duplex) and 7 (collision test). All other bits read 0.
- R7: A control write with bit 12 set also sets status bit 5 (autonegotiation complete).
- R8: A write to address 4 keeps bits 13, 11, 10, 8, 6, 5 and 4:0. Bit 7 (100BASE-TX half duplex) always reads 1, and all other bits read 0.
- R9: A rising edge of `link_down` clears status bits 5 and 2 and sets pending bit 4.
- R10: A falling edge of `link_down` sets status bits 5 and 2 and sets pending bits 7 and 6.
- R11: Address 2 reads `ID_HI`, address 3 reads `ID_LO`, address 5 reads 0x0FE1 and address 6 reads 0x0001.
- R12: Addresses other than 0 to 6, 29 and 30 read 0. Writes to them, and writes to read-only addresses 1, 2, 3, 5, 6 and 29, change no register.
- R13: A link edge in the same cycle as a read of address 29 leaves its new pending bits set after the read.
- R14: `rd_data` takes the addressed value one cycle after `rd_en` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| link_down | input | 1 | Line-side link-down level |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives a link edge in the same cycle as the clear-on-read of the pending register. A design that lets the clear win would lose the cause, and the following read would return 0 instead of 0x00C0. It changes the mask while causes are pending, so that an interrupt computed from stale state shows as `irq` stuck high or low. It writes all-ones into control and advertisement, which exposes wrong keep masks or a missing forced 100-half bit. It issues a soft reset after changing every register, which shows a reset that skips the mask or fails to apply the link level again.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;
    localparam int SRC_W  = 8;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL    = 5'd0,
        SEL_STAT    = 5'd1,
        SEL_ID_HI   = 5'd2,
        SEL_ID_LO   = 5'd3,
        SEL_ADV     = 5'd4,
        SEL_PARTNER = 5'd5,
        SEL_EXPAN   = 5'd6,
        SEL_SRC     = 5'd29,
        SEL_MASK    = 5'd30
    } reg_sel_e;

    // control bit positions
    localparam int CB_SOFT_RST = 15;
    localparam int CB_AN_EN    = 12;
    // status bit positions
    localparam int SB_AN_DONE  = 5;
    localparam int SB_LINK     = 2;
    // pending-cause bit positions
    localparam int IB_ENERGY   = 7;
    localparam int IB_AN_DONE  = 6;
    localparam int IB_DOWN     = 4;

    localparam logic [DATA_W-1:0] CTRL_KEEP   = 16'h7980;
    localparam logic [DATA_W-1:0] CTRL_RST    = 16'h3000;
    localparam logic [DATA_W-1:0] STAT_RST    = 16'h7809;
    localparam logic [DATA_W-1:0] ADV_KEEP    = 16'h2D7F;
    localparam logic [DATA_W-1:0] ADV_FORCED  = 16'h0080;
    localparam logic [DATA_W-1:0] ADV_RST     = 16'h01E1;
    localparam logic [DATA_W-1:0] PARTNER_VAL = 16'h0FE1;
    localparam logic [DATA_W-1:0] EXPAN_VAL   = 16'h0001;

    typedef struct packed {
        logic valid;
        logic down;
    } link_evt_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] adv;
    } core_regs_t;

    function automatic logic [DATA_W-1:0] stat_link(input logic [DATA_W-1:0] s,
                                                    input logic down);
        logic [DATA_W-1:0] r;
        r = s;
        r[SB_AN_DONE] = !down;
        r[SB_LINK]    = !down;
        return r;
    endfunction

    function automatic logic [SRC_W-1:0] link_causes(input logic down);
        logic [SRC_W-1:0] c;
        c = '0;
        if (down) begin
            c[IB_DOWN] = 1'b1;
        end else begin
            c[IB_ENERGY]  = 1'b1;
            c[IB_AN_DONE] = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/phy_link_tracker.sv
module phy_link_tracker
    import phy_mgmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_any,
    input  logic      link_down,
    output link_evt_t evt
);
    logic link_prev;

    always_ff @(posedge clk) begin
        link_prev <= link_down;
    end

    always_comb begin
        evt.valid = !rst_any && (link_down != link_prev);
        evt.down  = link_down;
    end
endmodule

// File: rtl/phy_core_regs.sv
module phy_core_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_any,
    input  logic              wr_ctrl,
    input  logic              wr_adv,
    input  logic [DATA_W-1:0] wdata,
    input  logic              link_down,
    input  link_evt_t         evt,
    output core_regs_t        regs
);
    logic [DATA_W-1:0] stat_n;

    always_comb begin
        stat_n = regs.stat;
        if (wr_ctrl && wdata[CB_AN_EN]) begin
            stat_n[SB_AN_DONE] = 1'b1;
        end
        if (evt.valid) begin
            stat_n = stat_link(stat_n, evt.down);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            regs.ctrl <= CTRL_RST;
            regs.stat <= stat_link(STAT_RST, link_down);
            regs.adv  <= ADV_RST;
        end else begin
            if (wr_ctrl) begin
                regs.ctrl <= wdata & CTRL_KEEP;
            end
            if (wr_adv) begin
                regs.adv <= (wdata & ADV_KEEP) | ADV_FORCED;
            end
            regs.stat <= stat_n;
        end
    end

    p_ctl_store_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !rst_any) |=> (regs.ctrl == ($past(wdata) & CTRL_KEEP)));

    p_an_done_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata[CB_AN_EN] && !evt.valid && !rst_any) |=> regs.stat[SB_AN_DONE]);

    p_adv_store_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_adv && !rst_any) |=> (regs.adv == (($past(wdata) & ADV_KEEP) | ADV_FORCED)));

    p_link_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.down && !rst_any) |=> (!regs.stat[SB_AN_DONE] && !regs.stat[SB_LINK]));

    p_link_rise_r10: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && !evt.down && !rst_any) |=> (regs.stat[SB_AN_DONE] && regs.stat[SB_LINK]));
endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
    import phy_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_any,
    input  logic             link_down,
    input  link_evt_t        evt,
    input  logic             clr_src,
    input  logic             wr_mask,
    input  logic [SRC_W-1:0] mask_data,
    output logic [SRC_W-1:0] src,
    output logic [SRC_W-1:0] mask,
    output logic             irq
);
    logic [SRC_W-1:0] src_n;

    always_comb begin
        src_n = clr_src ? '0 : src;
        if (evt.valid) begin
            src_n = src_n | link_causes(evt.down);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            src  <= link_causes(link_down);
            mask <= '0;
        end else begin
            src <= src_n;
            if (wr_mask) begin
                mask <= mask_data;
            end
        end
    end

    assign irq = |(src & mask);

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_src && !evt.valid && !rst_any) |=> (src == '0) && !irq);

    p_mask_store_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_mask && !rst_any) |=> (mask == $past(mask_data)));

    p_keep_event_r13: assert property (@(posedge clk) disable iff (rst)
        (clr_src && evt.valid && !rst_any) |=> (src == $past(link_causes(evt.down))));
endmodule

// File: rtl/phy_read_mux.sv
module phy_read_mux
    import phy_mgmt_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_HI = 16'h0181,
    parameter logic [DATA_W-1:0] ID_LO = 16'hB8A1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  core_regs_t        regs,
    input  logic [SRC_W-1:0]  src,
    input  logic [SRC_W-1:0]  mask,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sel_val;
    logic              hit;

    always_comb begin
        hit = 1'b1;
        case (reg_sel_e'(addr))
            SEL_CTRL:    sel_val = regs.ctrl;
            SEL_STAT:    sel_val = regs.stat;
            SEL_ID_HI:   sel_val = ID_HI;
            SEL_ID_LO:   sel_val = ID_LO;
            SEL_ADV:     sel_val = regs.adv;
            SEL_PARTNER: sel_val = PARTNER_VAL;
            SEL_EXPAN:   sel_val = EXPAN_VAL;
            SEL_SRC:     sel_val = {{(DATA_W-SRC_W){1'b0}}, src};
            SEL_MASK:    sel_val = {{(DATA_W-SRC_W){1'b0}}, mask};
            default: begin
                sel_val = '0;
                hit     = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= sel_val;
        end
    end

    p_undecoded_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !hit) |=> (rd_data == '0));

    p_hold_r14: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter logic [15:0] ID_HI = 16'h0181,
    parameter logic [15:0] ID_LO = 16'hB8A1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        link_down,
    output logic [15:0] rd_data,
    output logic        irq
);
    logic       soft_rst;
    logic       rst_any;
    logic       wr_ctrl;
    logic       wr_adv;
    logic       wr_mask;
    logic       clr_src;
    link_evt_t  evt;
    core_regs_t regs;
    logic [SRC_W-1:0] src;
    logic [SRC_W-1:0] mask;

    always_comb begin
        soft_rst = wr_en && (reg_addr == SEL_CTRL) && wr_data[CB_SOFT_RST];
        rst_any  = rst || soft_rst;
        wr_ctrl  = wr_en && (reg_addr == SEL_CTRL) && !wr_data[CB_SOFT_RST];
        wr_adv   = wr_en && (reg_addr == SEL_ADV);
        wr_mask  = wr_en && (reg_addr == SEL_MASK);
        clr_src  = rd_en && (reg_addr == SEL_SRC);
    end

    phy_link_tracker u_link (
        .clk       (clk),
        .rst_any   (rst_any),
        .link_down (link_down),
        .evt       (evt)
    );

    phy_core_regs u_core (
        .clk       (clk),
        .rst       (rst),
        .rst_any   (rst_any),
        .wr_ctrl   (wr_ctrl),
        .wr_adv    (wr_adv),
        .wdata     (wr_data),
        .link_down (link_down),
        .evt       (evt),
        .regs      (regs)
    );

    phy_irq_unit u_irq (
        .clk       (clk),
        .rst       (rst),
        .rst_any   (rst_any),
        .link_down (link_down),
        .evt       (evt),
        .clr_src   (clr_src),
        .wr_mask   (wr_mask),
        .mask_data (wr_data[SRC_W-1:0]),
        .src       (src),
        .mask      (mask),
        .irq       (irq)
    );

    phy_read_mux #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .addr    (reg_addr),
        .regs    (regs),
        .src     (src),
        .mask    (mask),
        .rd_data (rd_data)
    );

    p_soft_reset_r5: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (regs.ctrl == CTRL_RST) && (regs.adv == ADV_RST) && (mask == '0));

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (regs.ctrl == CTRL_RST) && (mask == '0) && !irq);
endmodule

// File: tb/phy_mgmt_regs_tb_top.sv
module phy_mgmt_regs_tb_top;
    localparam logic [15:0] ID_HI = 16'h0181;
    localparam logic [15:0] ID_LO = 16'hB8A1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        link_down = 1'b0;
    logic [15:0] rd_data;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    logic rd_pend = 1'b0;

    always #2.5 clk = ~clk;

    phy_mgmt_regs #(.ID_HI(ID_HI), .ID_LO(ID_LO)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .link_down (link_down),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    function automatic void check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // monitor: a read strobe seen at a rising edge yields data by the next falling edge
    always @(posedge clk) rd_pend <= rd_en;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (sb_q.size() == 0) begin
                check("R14 unexpected read data", rd_data, 16'hxxxx);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, rd_data, e.exp);
            end
        end
    end

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        reg_addr = a;
        rd_en    = 1'b1;
        e.exp    = exp;
        e.tag    = tag;
        sb_q.push_back(e);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_down = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        check(tag, {15'd0, irq}, {15'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, link up
        chk_irq(1'b0, "R1 irq after reset");
        rd(5'd0,  16'h3000, "R1 control reset");
        rd(5'd1,  16'h782D, "R1 status reset");
        rd(5'd4,  16'h01E1, "R1 advert reset");
        rd(5'd30, 16'h0000, "R1 mask reset");
        // R11 fixed words
        rd(5'd2, ID_HI,    "R11 id high");
        rd(5'd3, ID_LO,    "R11 id low");
        rd(5'd5, 16'h0FE1, "R11 partner ability");
        rd(5'd6, 16'h0001, "R11 expansion");
        // R3 clear on read
        rd(5'd29, 16'h00C0, "R3 pending after reset");
        rd(5'd29, 16'h0000, "R3 pending cleared");
        // R4 mask stores low byte
        wr(5'd30, 16'hFFFF);
        rd(5'd30, 16'h00FF, "R4 mask low byte");
        chk_irq(1'b0, "R2 no pending no irq");
        // R9 link down
        set_link(1'b1);
        chk_irq(1'b1, "R2 irq on link down");
        rd(5'd1,  16'h7809, "R9 status after drop");
        rd(5'd29, 16'h0010, "R9 down cause");
        chk_irq(1'b0, "R3 irq low after clear");
        // R10 link up, mask re-evaluation
        wr(5'd30, 16'h0040);
        set_link(1'b0);
        chk_irq(1'b1, "R10 irq on link up");
        wr(5'd30, 16'h0010);
        chk_irq(1'b0, "R4 mask change drops irq");
        rd(5'd1,  16'h782D, "R10 status after rise");
        rd(5'd29, 16'h00C0, "R10 up causes");
        // R6 control keep mask
        wr(5'd0, 16'h7FFF);
        rd(5'd0, 16'h7980, "R6 control keep bits");
        // R7 autoneg complete on write
        set_link(1'b1);
        rd(5'd29, 16'h0010, "R9 second drop cause");
        rd(5'd1,  16'h7809, "R7 status before write");
        wr(5'd0, 16'h1000);
        rd(5'd1, 16'h7829, "R7 status autoneg done");
        rd(5'd0, 16'h1000, "R6 control value");
        // R8 advertisement
        wr(5'd4, 16'hFFFF);
        rd(5'd4, 16'h2DFF, "R8 advert keep bits");
        wr(5'd4, 16'h0000);
        rd(5'd4, 16'h0080, "R8 forced tx half");
        // R12 undecoded and read-only
        wr(5'd17, 16'hFFFF);
        wr(5'd1,  16'h0000);
        wr(5'd29, 16'hFFFF);
        wr(5'd31, 16'hFFFF);
        rd(5'd17, 16'h0000, "R12 addr 17 reads zero");
        rd(5'd31, 16'h0000, "R12 addr 31 reads zero");
        rd(5'd12, 16'h0000, "R12 addr 12 reads zero");
        rd(5'd1,  16'h7829, "R12 status unchanged");
        rd(5'd29, 16'h0000, "R12 pending unchanged");
        rd(5'd4,  16'h0080, "R12 advert unchanged");
        // R13 link edge during clear-on-read
        begin
            exp_t e;
            @(negedge clk);
            link_down = 1'b0;
            reg_addr  = 5'd29;
            rd_en     = 1'b1;
            e.exp = 16'h0000;
            e.tag = "R13 read during edge";
            sb_q.push_back(e);
            @(negedge clk);
            rd_en = 1'b0;
        end
        rd(5'd29, 16'h00C0, "R13 cause kept");
        rd(5'd1,  16'h782D, "R10 status after rise 2");
        // R5 soft reset
        set_link(1'b1);
        set_link(1'b0);
        wr(5'd30, 16'h00FF);
        chk_irq(1'b1, "R2 irq before soft reset");
        wr(5'd0, 16'h8000);
        chk_irq(1'b0, "R5 irq after soft reset");
        rd(5'd0,  16'h3000, "R5 control");
        rd(5'd4,  16'h01E1, "R5 advert");
        rd(5'd30, 16'h0000, "R5 mask");
        rd(5'd1,  16'h782D, "R5 status");
        rd(5'd29, 16'h00C0, "R5 pending");
        // R14 hold
        repeat (4) @(negedge clk);
        check("R14 read data held", rd_data, 16'h00C0);
        check("R14 scoreboard drained", 16'(sb_q.size()), 16'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule